// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Bank

This block is a register-mapped bank of up to 32 general-purpose I/O pins. Every pin owns a configuration word that sets whether the pin samples its pad and whether it drives it. The same word enables an interrupt and picks what triggers it. Three shared words gather the per-pin results: sticky interrupt flags, synchronised input values and the output data that the pads drive.

Software reaches the bank through a plain 32-bit bus with a byte address and a one-cycle write strobe. Read data is combinational from the address. Pad inputs pass through a multi-flop synchroniser before any logic sees them. One combined interrupt line reports whether any flag is pending. The pin count, the address width and the synchroniser depth are parameters.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset, every configuration word, the output data word and the interrupt status word read zero, `pad_oe` and `pad_out` are all zero, and `irq` is low.
- R2: Pin i (i < NUM_PINS) has its configuration word at byte offset 4*i. Only bits [3:0] and [7:5] are stored. Bit 4 and bits [31:8] read zero.
- R3: One cycle after a write to pin i's configuration word, `pad_oe[i]` is 1 exactly when bit 0 (drive enable) and bit 2 (buffer enable) are both set. `pad_out[i]` always equals bit i of the output data word.
- R4: The output data word at offset 0x88 reads back the stored pin bits. Bits at NUM_PINS and above read zero.
- R5: In the input data word at offset 0x84, bit i is pad_in[i] after two register stages, ANDed with configuration bit 1 (sample enable). A pad change made before rising edge k is visible after edge k+1 and not after edge k.
- R6: Configuration bits [7:5] select the trigger: 0 is level high, 1 is level low, 2 is rising edge, 3 is falling edge and 4 is either edge. Codes 5 to 7 never trigger. Nothing triggers unless bit 3 (interrupt enable) is set. A qualifying pad change made before edge k sets the status bit at edge k+2.
- R7: Status bits at offset 0x80 are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A trigger present in the cycle of the clearing write wins, so a persisting level keeps its bit set.
- R8: `irq` is high exactly when any status bit is set.
- R9: Reads of every unmapped word return zero, and writes to them change no register. Unmapped words are the configuration slots of pins NUM_PINS and above, and every word past 0x88.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | NUM_PINS | Asynchronous pad input values |
| pad_out | output | NUM_PINS | Values driven toward the pads |
| pad_oe | output | NUM_PINS | Per-pad output drive enable |
| irq | output | 1 | OR of all interrupt status bits |

## Verification
A corrupted configuration bit shows on the next cycle, either on `pad_oe` or in the word read back at its offset. A broken synchroniser or edge delay flop shows as a status bit or input bit that is one edge early or late, or a status bit that never sets, within three edges of a pad change. Status state that is lost or sticks shows on `irq` at once. A wrong clear mask shows up in the status word on the next read. The trigger sweep drives every code through the same pad sequence on every pin, so a swapped decode shows on the first affected pin.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [2:0] {
      TRIG_HIGH = 3'd0,
      TRIG_LOW  = 3'd1,
      TRIG_RISE = 3'd2,
      TRIG_FALL = 3'd3,
      TRIG_BOTH = 3'd4
   } trig_e;

   typedef struct packed {
      logic [2:0] trig;
      logic       irq_en;
      logic       buf_en;
      logic       smp_en;
      logic       drv_en;
   } pin_cfg_t;

   localparam int unsigned STAT_WORD = 32;
   localparam int unsigned IN_WORD   = 33;
   localparam int unsigned OUT_WORD  = 34;

   function automatic pin_cfg_t word_to_cfg(input logic [7:0] w);
      pin_cfg_t c;
      c.drv_en = w[0];
      c.smp_en = w[1];
      c.buf_en = w[2];
      c.irq_en = w[3];
      c.trig   = w[7:5];
      return c;
   endfunction

   function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
      return {24'd0, c.trig, 1'b0, c.irq_en, c.buf_en, c.smp_en, c.drv_en};
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= async_i;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
   import gpio_bank_pkg::*;
(
   input  logic       level_i,
   input  logic       level_d_i,
   input  logic [2:0] trig_i,
   output logic       hit_o
);
   logic rise, fall;

   assign rise = level_i & ~level_d_i;
   assign fall = ~level_i & level_d_i;

   always_comb begin
      unique case (trig_e'(trig_i))
         TRIG_HIGH: hit_o = level_i;
         TRIG_LOW:  hit_o = ~level_i;
         TRIG_RISE: hit_o = rise;
         TRIG_FALL: hit_o = fall;
         TRIG_BOTH: hit_o = rise | fall;
         default:   hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/gpio_pin_lane.sv
module gpio_pin_lane
   import gpio_bank_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_we,
   input  pin_cfg_t cfg_wr,
   input  logic     stat_clr,
   input  logic     pin_sync,
   output pin_cfg_t cfg_q,
   output logic     stat_q,
   output logic     in_bit,
   output logic     oe
);
   logic pin_d;
   logic hit;

   gpio_trig_detect u_det (
      .level_i   (pin_sync),
      .level_d_i (pin_d),
      .trig_i    (cfg_q.trig),
      .hit_o     (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         pin_d  <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         if (cfg_we) cfg_q <= cfg_wr;
         pin_d  <= pin_sync;
         stat_q <= (stat_q & ~stat_clr) | (cfg_q.irq_en & hit);
      end
   end

   assign in_bit = pin_sync & cfg_q.smp_en;
   assign oe     = cfg_q.drv_en & cfg_q.buf_en;
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);
   localparam int WORD_W = ADDR_W - 2;

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("gpio_pin_bank: NUM_PINS must lie in 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_pin_bank: ADDR_W must be at least 8");
   end

   logic [WORD_W-1:0]   word_idx;
   logic                wr_stat, wr_out;
   logic [NUM_PINS-1:0] stat_clr, stat_vec, in_vec, pin_sync, out_q;
   pin_cfg_t            wr_cfg;
   pin_cfg_t            cfg_arr [NUM_PINS];
   logic                unused_bits;

   assign word_idx = bus_addr[ADDR_W-1:2];
   assign wr_stat  = bus_wr && (word_idx == WORD_W'(STAT_WORD));
   assign wr_out   = bus_wr && (word_idx == WORD_W'(OUT_WORD));
   assign stat_clr = wr_stat ? bus_wdata[NUM_PINS-1:0] : '0;
   assign wr_cfg   = word_to_cfg(bus_wdata[7:0]);
   assign unused_bits = ^{bus_wdata[31:8], bus_wdata[4], bus_addr[1:0]};

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pad_in),
      .sync_o  (pin_sync)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
      logic sel;
      assign sel = bus_wr && (word_idx == WORD_W'(p));
      gpio_pin_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (sel),
         .cfg_wr   (wr_cfg),
         .stat_clr (stat_clr[p]),
         .pin_sync (pin_sync[p]),
         .cfg_q    (cfg_arr[p]),
         .stat_q   (stat_vec[p]),
         .in_bit   (in_vec[p]),
         .oe       (pad_oe[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (wr_out) out_q <= bus_wdata[NUM_PINS-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (word_idx == WORD_W'(STAT_WORD))     bus_rdata = 32'(stat_vec);
      else if (word_idx == WORD_W'(IN_WORD))  bus_rdata = 32'(in_vec);
      else if (word_idx == WORD_W'(OUT_WORD)) bus_rdata = 32'(out_q);
      else begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (word_idx == WORD_W'(p)) bus_rdata = cfg_to_word(cfg_arr[p]);
         end
      end
   end

   assign pad_out = out_q;
   assign irq     = |stat_vec;
endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk #(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                irq,
   input logic [NUM_PINS-1:0] stat_vec
);
   localparam int WW = ADDR_W - 2;

   logic [WW-1:0]       widx;
   logic [NUM_PINS-1:0] clr_m;
   logic                unmapped;

   assign widx     = bus_addr[ADDR_W-1:2];
   assign clr_m    = (bus_wr && widx == WW'(32)) ? bus_wdata[NUM_PINS-1:0] : '0;
   assign unmapped = (widx > WW'(34)) || ((widx >= WW'(NUM_PINS)) && (widx < WW'(32)));

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(stat_vec) & ~stat_vec) & ~$past(clr_m)) == '0)); // R7

   AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && widx == WW'(34)) |=> (pad_out == $past(bus_wdata[NUM_PINS-1:0]))); // R3

   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == WW'(32)) |-> (irq == (bus_rdata != 32'd0))); // R8

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (bus_rdata == 32'd0)); // R9

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
      AST_OE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && widx == WW'(p)) |=>
            (pad_oe[p] == ($past(bus_wdata[0]) && $past(bus_wdata[2])))); // R3
   end
endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq),
   .stat_vec  (stat_vec)
);

// File: tb/tb_gpio_pin_bank.sv
module tb_gpio_pin_bank;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;

   gpio_pin_bank #(.NUM_PINS(NP), .ADDR_W(8), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic exp_stat(input int ph, input int t, input int en);
      logic e;
      case (ph)
         0: e = (t == 1);
         1: e = (t == 1);
         2: e = (t == 0) || (t == 1) || (t == 2) || (t == 4);
         3: e = (t == 0);
         4: e = (t == 0) || (t == 1) || (t == 3) || (t == 4);
         default: e = (t == 1);
      endcase
      return e && (en != 0);
   endfunction

   task automatic chk_stat(input string req, input logic [31:0] exp);
      logic [31:0] v;
      rd(8'h80, v);
      check(req, v, exp);
      check({req, " irq"}, {31'd0, irq}, {31'd0, exp != 0});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      for (int p = 0; p < NP; p++) begin
         rd(8'(4 * p), v);
         check("R1 cfg", v, 0);
      end
      rd(8'h80, v); check("R1 status", v, 0);
      rd(8'h88, v); check("R1 output", v, 0);
      check("R1 pads", {28'd0, pad_oe | pad_out}, 0);
      check("R1 irq", {31'd0, irq}, 0);

      // R2 config readback with masking
      for (int p = 0; p < NP; p++) begin
         wr(8'(4 * p), 32'hFFFF_FFFF);
         rd(8'(4 * p), v); check("R2 ones", v, 32'h0000_00EF);
         wr(8'(4 * p), 32'hA5A5_A5A5);
         rd(8'(4 * p), v); check("R2 pattern", v, 32'h0000_00A5);
         wr(8'(4 * p), 0);
      end

      // R9 unmapped words
      for (int w = NP; w < 64; w++) begin
         if (w != 32 && w != 33 && w != 34) begin
            wr(8'(4 * w), 32'hFFFF_FFFF);
            rd(8'(4 * w), v);
            check("R9 unmapped", v, 0);
         end
      end
      for (int p = 0; p < NP; p++) begin
         rd(8'(4 * p), v); check("R9 cfg untouched", v, 0);
      end
      rd(8'h88, v); check("R9 output untouched", v, 0);

      // R3 drive enable rule, all low config codes on every pin
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < 8; c++) begin
            wr(8'(4 * p), 32'(c));
            check("R3 pad_oe", {28'd0, pad_oe}, ((c & 5) == 5) ? (32'd1 << p) : 32'd0);
         end
         wr(8'(4 * p), 0);
      end

      // R4 / R3 output data word
      for (int d = 0; d < 16; d++) begin
         wr(8'h88, 32'(d) | 32'hA5A5_0000);
         rd(8'h88, v);
         check("R4 readback", v, 32'(d));
         check("R3 pad_out", {28'd0, pad_out}, 32'(d));
      end
      wr(8'h88, 32'hFFFF_FFF0);
      rd(8'h88, v); check("R4 upper masked", v, 0);

      // R5 synchroniser latency
      for (int p = 0; p < NP; p++) wr(8'(4 * p), 32'h2);
      pad_in = 4'hA;
      tick(1);
      rd(8'h84, v); check("R5 one edge", v, 0);
      tick(1);
      rd(8'h84, v); check("R5 two edges", v, 32'hA);

      // R5 sample enable mask sweep
      for (int m = 0; m < 16; m++) begin
         for (int p = 0; p < NP; p++) wr(8'(4 * p), m[p] ? 32'h2 : 32'h0);
         for (int d = 0; d < 16; d++) begin
            pad_in = 4'(d);
            tick(2);
            rd(8'h84, v);
            check("R5 sweep", v, 32'(d & m));
         end
      end
      pad_in = '0;
      for (int p = 0; p < NP; p++) wr(8'(4 * p), 0);
      tick(4);

      // R6 / R7 / R8 trigger sweep
      for (int p = 0; p < NP; p++) begin
         for (int en = 0; en < 2; en++) begin
            for (int t = 0; t < 8; t++) begin
               wr(8'(4 * p), 32'((t << 5) | (en << 3) | 2));
               tick(4);
               chk_stat("R6 phase idle", 32'(exp_stat(0, t, en)) << p);
               wr(8'h80, 32'hF);
               chk_stat("R7 clear low", 32'(exp_stat(1, t, en)) << p);
               pad_in[p] = 1'b1;
               tick(4);
               chk_stat("R6 after rise", 32'(exp_stat(2, t, en)) << p);
               wr(8'h80, 32'hF);
               chk_stat("R7 clear high", 32'(exp_stat(3, t, en)) << p);
               pad_in[p] = 1'b0;
               tick(4);
               chk_stat("R6 after fall", 32'(exp_stat(4, t, en)) << p);
               wr(8'h80, 32'hF);
               chk_stat("R7 clear end", 32'(exp_stat(5, t, en)) << p);
               wr(8'(4 * p), 0);
               wr(8'h80, 32'hF);
               chk_stat("R8 idle", 0);
            end
         end
      end

      // R7 selective clear
      wr(8'h00, 32'h4A);
      wr(8'h04, 32'h4A);
      pad_in = 4'h3;
      tick(4);
      chk_stat("R7 both set", 32'h3);
      wr(8'h80, 32'h1);
      chk_stat("R7 clear bit0 only", 32'h2);
      wr(8'h80, 32'h0);
      chk_stat("R7 zero write", 32'h2);
      wr(8'h80, 32'h2);
      chk_stat("R7 clear bit1", 32'h0);

      // R1 reset mid-run
      wr(8'h88, 32'hF);
      wr(8'h08, 32'h07);
      wr(8'h0C, 32'h08);
      tick(4);
      rst_n = 1'b0;
      #1;
      check("R1 async pads", {28'd0, pad_oe | pad_out}, 0);
      check("R1 async irq", {31'd0, irq}, 0);
      tick(1);
      rst_n = 1'b1;
      tick(1);
      rd(8'h08, v); check("R1 cfg after reset", v, 0);
      rd(8'h88, v); check("R1 out after reset", v, 0);
      rd(8'h80, v); check("R1 status after reset", v, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule